// File: doc/BRIEF.md
# Threshold Interrupt Status Controller

This block keeps the interrupt state for a converter host interface. A ten-bit sticky status register collects seven alarm events, an over-temperature event, a "data queue above threshold" condition and a "command queue low" condition. A ten-bit mask register gates these bits onto a single level-sensitive interrupt line. Software clears a status bit by writing a one to its position.

The block does no register address decoding. A decoder outside it supplies one write strobe and a 32-bit write word for each of the two registers, and reads both registers back from the block's outputs. The data-queue condition compares the queue's fill level with a 4-bit threshold taken from a configuration field. The command queue never holds anything, because commands complete at once, so its "low" flag is set again on every clock.

Every clock edge re-evaluates the status. An event that arrives in the same cycle as a clear of its own bit leaves that bit set. The interrupt line is registered, so it follows status and mask changes one cycle later.

Top module: `irq_stat_ctrl`

## Requirements
- R1: After reset the status reads 0x200 (only bit 9 set), the mask reads 0x3FF and the interrupt line is low.
- R2: A status write clears each status bit whose write-data bit is one. Bits written as zero, and write-data bits 31:10, change nothing.
- R3: A one-cycle pulse on alarm input k (k = 0..6) sets status bit k. A pulse on the over-temperature input sets status bit 7. Each bit is set on the clock edge that samples the pulse.
- R4: Status bit 8 is set on a clock edge where the fill level is strictly greater than the threshold. A level equal to or below the threshold does not set it.
- R5: A set status bit stays set after its cause goes away, until a status write clears it.
- R6: Status bit 9 reads one in every cycle after reset, even right after a write of one to bit 9.
- R7: When a bit's set condition and a write-one clear of that bit occur on the same edge, the bit ends up set.
- R8: A mask write loads write-data bits 9:0 into the mask and ignores bits 31:10. With no mask write, the mask holds its value.
- R9: The interrupt line takes, one clock later, the OR over all bits of (status AND NOT mask).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sts_wr | input | 1 | Write strobe for the status register (write-one-to-clear) |
| sts_wdata | input | 32 | Write data for the status register |
| msk_wr | input | 1 | Write strobe for the mask register |
| msk_wdata | input | 32 | Write data for the mask register |
| dq_level | input | 5 | Current fill level of the data queue |
| dq_thresh | input | 4 | Data-queue threshold from the configuration field |
| alarm_evt | input | 7 | Alarm event pulses, one per alarm bit |
| ot_evt | input | 1 | Over-temperature event pulse |
| sts_q | output | 10 | Current status register value |
| msk_q | output | 10 | Current mask register value |
| irq | output | 1 | Registered level interrupt |

## Verification
The assertions check several rules on every cycle. A cleared bit with no set condition is zero on the next edge. Set conditions always land, even against a clear. Set bits stay set unless cleared. Bit 9 never drops. The mask loads only its ten low bits. The interrupt follows the masked status one cycle later. Only the bench's scenarios can show the strict boundary of the threshold compare (equal compared with one above). They also show that write-data bits above bit 9 do nothing, and that unmasking a long-standing status bit raises the interrupt exactly one cycle after the mask write.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  localparam int CMP_MAX_W = 16;

  // strict greater-than on zero-extended operands
  function automatic logic f_above(input logic [CMP_MAX_W-1:0] lvl,
                                   input logic [CMP_MAX_W-1:0] thr);
    return (lvl > thr);
  endfunction

  // any pending bit that the mask lets through
  function automatic logic f_pending(input logic [CMP_MAX_W-1:0] sts,
                                     input logic [CMP_MAX_W-1:0] msk);
    return |(sts & ~msk);
  endfunction

  // sticky update: set beats clear
  function automatic logic [CMP_MAX_W-1:0] f_sticky(input logic [CMP_MAX_W-1:0] cur,
                                                    input logic [CMP_MAX_W-1:0] clr,
                                                    input logic [CMP_MAX_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/ist_thresh_cmp.sv
module ist_thresh_cmp
  import irq_stat_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int THR_W = 4
) (
  input  logic [LVL_W-1:0] level,
  input  logic [THR_W-1:0] thresh,
  output logic             above
);
  logic [CMP_MAX_W-1:0] lvl_ext;
  logic [CMP_MAX_W-1:0] thr_ext;

  always_comb begin
    lvl_ext = '0;
    thr_ext = '0;
    lvl_ext[LVL_W-1:0] = level;
    thr_ext[THR_W-1:0] = thresh;
    above = f_above(lvl_ext, thr_ext);
  end
endmodule

// File: rtl/ist_status_reg.sv
module ist_status_reg
  import irq_stat_pkg::*;
#(
  parameter int              STS_W   = 10,
  parameter logic [STS_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] set_vec,
  input  logic [STS_W-1:0] clr_vec,
  output logic [STS_W-1:0] sts_q
);
  logic [CMP_MAX_W-1:0] nxt_ext;
  logic [STS_W-1:0]     sts_d;

  always_comb begin
    nxt_ext = f_sticky(CMP_MAX_W'(sts_q), CMP_MAX_W'(clr_vec), CMP_MAX_W'(set_vec));
    sts_d   = nxt_ext[STS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= RST_VAL;
    else        sts_q <= sts_d;
  end

  // R2: a clear with no competing set empties the bit
  a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & $past(clr_vec & ~set_vec)) == '0));

  // R3: every set request lands on the next edge
  a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & $past(set_vec)) == $past(set_vec)));

  // R5: uncleared bits are kept
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sts_q & ~clr_vec) & ~sts_q) == '0));

  // R7: set wins over a simultaneous clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_vec & clr_vec) & ~sts_q) == '0));
endmodule

// File: rtl/ist_mask_reg.sv
module ist_mask_reg #(
  parameter int STS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [STS_W-1:0] wdata,
  output logic [STS_W-1:0] msk_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  msk_q <= '1;
    else if (wr) msk_q <= wdata;
  end

  // R8: a write loads the low bits, otherwise the mask holds
  a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (msk_q == $past(wdata)));
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(msk_q));
endmodule

// File: rtl/ist_irq_gen.sv
module ist_irq_gen
  import irq_stat_pkg::*;
#(
  parameter int STS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] sts,
  input  logic [STS_W-1:0] msk,
  output logic             irq
);
  logic pend;

  always_comb pend = f_pending(CMP_MAX_W'(sts), CMP_MAX_W'(msk));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pend;
  end

  // R9: the line follows the masked status one cycle later
  a_r9_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == (|($past(sts) & ~$past(msk)))));
endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl #(
  parameter int DATA_W  = 32,
  parameter int NUM_ALM = 7,
  parameter int LVL_W   = 5,
  parameter int THR_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sts_wr,
  input  logic [DATA_W-1:0]       sts_wdata,
  input  logic                    msk_wr,
  input  logic [DATA_W-1:0]       msk_wdata,
  input  logic [LVL_W-1:0]        dq_level,
  input  logic [THR_W-1:0]        dq_thresh,
  input  logic [NUM_ALM-1:0]      alarm_evt,
  input  logic                    ot_evt,
  output logic [NUM_ALM+2:0]      sts_q,
  output logic [NUM_ALM+2:0]      msk_q,
  output logic                    irq
);
  localparam int STS_W   = NUM_ALM + 3;
  localparam int OT_BIT  = NUM_ALM;
  localparam int DQ_BIT  = NUM_ALM + 1;
  localparam int CQ_BIT  = NUM_ALM + 2;
  localparam logic [STS_W-1:0] STS_RST = STS_W'(1) << CQ_BIT;

  // named internal events
  logic             dq_above;
  logic [STS_W-1:0] set_vec;
  logic [STS_W-1:0] clr_vec;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^{sts_wdata[DATA_W-1:STS_W], msk_wdata[DATA_W-1:STS_W]};

  ist_thresh_cmp #(.LVL_W(LVL_W), .THR_W(THR_W)) u_cmp (
    .level (dq_level),
    .thresh(dq_thresh),
    .above (dq_above)
  );

  // set sources, one per status bit
  genvar gi;
  generate
    for (gi = 0; gi < NUM_ALM; gi++) begin : g_alm
      assign set_vec[gi] = alarm_evt[gi];
    end
  endgenerate
  assign set_vec[OT_BIT] = ot_evt;
  assign set_vec[DQ_BIT] = dq_above;
  assign set_vec[CQ_BIT] = 1'b1;   // command queue always drained

  assign clr_vec = sts_wr ? sts_wdata[STS_W-1:0] : '0;

  ist_status_reg #(.STS_W(STS_W), .RST_VAL(STS_RST)) u_sts (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .sts_q  (sts_q)
  );

  ist_mask_reg #(.STS_W(STS_W)) u_msk (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (msk_wr),
    .wdata(msk_wdata[STS_W-1:0]),
    .msk_q(msk_q)
  );

  ist_irq_gen #(.STS_W(STS_W)) u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .sts  (sts_q),
    .msk  (msk_q),
    .irq  (irq)
  );

  // R4: level above threshold is reflected in bit 8 next cycle
  a_r4_dq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_level > LVL_W'(dq_thresh)) |=> sts_q[DQ_BIT]);

  // R6: the command-queue-low flag never drops
  a_r6_cq_held: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sts_q[CQ_BIT]);
endmodule

// File: tb/irq_stat_ctrl_bench.sv
module irq_stat_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sts_wr = 1'b0;
  logic [31:0] sts_wdata = '0;
  logic        msk_wr = 1'b0;
  logic [31:0] msk_wdata = '0;
  logic [4:0]  dq_level = '0;
  logic [3:0]  dq_thresh = '0;
  logic [6:0]  alarm_evt = '0;
  logic        ot_evt = 1'b0;
  logic [9:0]  sts_q;
  logic [9:0]  msk_q;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state
  int exp_sts;
  int exp_msk;
  int exp_irq;

  always #5 clk = ~clk;

  irq_stat_ctrl u_irq_stat_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .msk_wr(msk_wr), .msk_wdata(msk_wdata),
    .dq_level(dq_level), .dq_thresh(dq_thresh),
    .alarm_evt(alarm_evt), .ot_evt(ot_evt),
    .sts_q(sts_q), .msk_q(msk_q), .irq(irq)
  );

  task automatic compare(input string tag);
    n_cmp++;
    if (int'(sts_q) != exp_sts) begin
      n_bad++;
      $display("FAIL %s status act=%03h exp=%03h", tag, sts_q, exp_sts);
    end
    n_cmp++;
    if (int'(msk_q) != exp_msk) begin
      n_bad++;
      $display("FAIL %s mask act=%03h exp=%03h", tag, msk_q, exp_msk);
    end
    n_cmp++;
    if (int'(irq) != exp_irq) begin
      n_bad++;
      $display("FAIL %s irq act=%0d exp=%0d", tag, irq, exp_irq);
    end
  endtask

  // advance one clock with the inputs currently driven; update the model
  task automatic tick(input string tag);
    int ns, nm, ni;
    ni = 0;
    for (int b = 0; b < 10; b++)
      if (((exp_sts >> b) & 1) == 1 && ((exp_msk >> b) & 1) == 0) ni = 1;
    ns = 0;
    for (int b = 0; b < 10; b++) begin
      bit keep, raise;
      keep = ((exp_sts >> b) & 1) == 1;
      if (sts_wr && sts_wdata[b]) keep = 1'b0;
      if (b == 9)      raise = 1'b1;
      else if (b == 8) raise = (int'(dq_level) > int'(dq_thresh));
      else if (b == 7) raise = ot_evt;
      else             raise = alarm_evt[b];
      if (keep || raise) ns = ns + (1 << b);
    end
    nm = msk_wr ? int'(msk_wdata % 1024) : exp_msk;
    @(posedge clk);
    exp_sts = ns; exp_msk = nm; exp_irq = ni;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    sts_wr = 0; sts_wdata = '0; msk_wr = 0; msk_wdata = '0;
    alarm_evt = '0; ot_evt = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    exp_sts = 'h200; exp_msk = 'h3FF; exp_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset state");
    tick("R1 R6 idle");

    // R4: equal does not set, one above does
    dq_thresh = 4'd5; dq_level = 5'd5;
    tick("R4 level equal threshold");
    dq_level = 5'd6;
    tick("R4 level above threshold");
    // R5: stays set after level drops
    dq_level = 5'd0;
    tick("R5 dq sticky");
    tick("R5 dq sticky again");

    // R8: upper mask bits ignored, unmask bit 8 -> R9 irq one cycle later
    msk_wr = 1; msk_wdata = 32'hFFFF_FEFF;
    tick("R8 mask write");
    idle();
    tick("R9 irq after unmask");
    tick("R9 irq held");

    // R2: upper write bits and zeros do nothing; then clear bit 8
    sts_wr = 1; sts_wdata = 32'hFFFF_FC00;
    tick("R2 upper bits ignored");
    sts_wdata = 32'h0000_0100;
    tick("R2 clear dq bit");
    idle();
    tick("R9 irq drops");

    // R3: alarms and over-temperature
    alarm_evt = 7'b101_0011;
    tick("R3 alarm pulse");
    idle();
    ot_evt = 1;
    tick("R3 over-temp pulse");
    idle();
    msk_wr = 1; msk_wdata = 32'h0000_0000;
    tick("R9 unmask all");
    idle();
    tick("R9 irq with all unmasked");

    // R7: set and clear same bit same edge
    alarm_evt = 7'b000_0001; sts_wr = 1; sts_wdata = 32'h0000_0081;
    tick("R7 set beats clear");
    idle();
    // R6: writing one to bit 9
    sts_wr = 1; sts_wdata = 32'h0000_03FF;
    tick("R6 clear attempt on bit 9");
    idle();
    tick("R9 only bit 9 pending");

    // R4 boundary at top of threshold range
    dq_thresh = 4'd15; dq_level = 5'd15;
    tick("R4 level 15 thr 15");
    dq_level = 5'd16;
    tick("R4 level 16 thr 15");
    dq_thresh = 4'd0; dq_level = 5'd0;
    sts_wr = 1; sts_wdata = 32'h0000_0100;
    tick("R2 clear dq after boundary");
    idle();
    msk_wr = 1; msk_wdata = 32'h0000_03FF;
    tick("R8 mask all");
    idle();
    tick("R9 irq low when masked");
    tick("R8 mask holds");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule